// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Masked Output Writes and Shared Interrupt

This block drives and samples sixteen general-purpose pins through a small word-addressed register bus. Software picks each pin's direction, changes output levels through a single 32-bit store, and reads the synchronized pin levels. The store needs no read-modify-write. Its upper half names the pins to change and its lower half gives their new levels.

The upper eight pins feed one shared, active-high interrupt request. Each level is gated by its own enable bit, and the gated terms are ORed together. A control register holds a clock-run bit and a hold-in-reset bit. After power-on reset the block sits held in reset with its clock stopped. It does nothing until software writes that control register. The usual bring-up writes 3 and then 1. Writing 2 parks the block in its low-power state.

Top module: `pinbank_ctl`

## Requirements
- R1: After the synchronous reset `rst`, the control register holds hold-in-reset set and clock-run clear. `pin_oe`, `pin_out` and `irq_shared` are 0, and every read returns 0.
- R2: While clock-run (control bit 0) is 0, writes to every register except control are ignored, and every read returns 0, including a read of control.
- R3: While hold-in-reset (control bit 1) is 1, the direction, output and interrupt-enable registers read back as 0 from the next cycle onward, and writes to them are ignored.
- R4: The direction register is at byte offset 0x00. A 1 in bit n makes pin n an output (`pin_oe[n]`=1). A 0 makes it an input. It reads back in bits 15:0.
- R5: The output register is at offset 0x08. A write changes pin n to data bit n only when data bit 16+n is 1. Other pins keep their level. For example, 0x00010001<<n sets pin n and 0x00010000<<n clears it. It reads back in bits 15:0 with bits 31:16 as 0.
- R6: Pin-state at offset 0x0C returns `pin_in` after two clock edges of synchronization. Writes to it have no effect.
- R7: `irq_shared` is the OR over pins 8 to 15 of synchronized level AND interrupt-enable bit. The interrupt-enable register is at offset 0x10. Enable bits 0 to 7 are stored and read back but never raise the request.
- R8: The control register is at offset 0x14 with bit 0 = clock-run and bit 1 = hold-in-reset. It is writable in every state. It reads back in bits 1:0 while clock-run is 1.
- R9: Offset 0x04 and offsets 0x18 and 0x1C read as 0, and writes to them change no state.
- R10: The input synchronizer advances only while clock-run is 1. While clock-run is 0, the sampled levels and the interrupt request derived from them are frozen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 5 | Byte address of the register; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_oe | output | 16 | Per-pin output enable (direction) |
| pin_out | output | 16 | Per-pin output level |
| irq_shared | output | 1 | Shared active-high interrupt from pins 8 to 15 |

## Verification
Output stores are tried with four kinds of write: a single-pin set, a single-pin clear, a full mask, and an empty mask. The set and clear separate the enable half from the value half. The full mask catches a block that ignores the mask. The empty mask catches one that writes anyway. Enable patterns placed only in the lower byte, then single bits at pins 8 and 15, separate the shared request from the stored-only bits and show both ends of the OR. Changing the pins while the clock is stopped separates a frozen synchronizer from a free-running one.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    // Register word index = byte offset >> 2
    typedef enum logic [2:0] {
        RG_DIR = 3'd0,
        RG_RSV = 3'd1,
        RG_OUT = 3'd2,
        RG_LVL = 3'd3,
        RG_IEN = 3'd4,
        RG_CTL = 3'd5,
        RG_X6  = 3'd6,
        RG_X7  = 3'd7
    } reg_sel_e;

    // bit 1 = hold in reset, bit 0 = clock run
    typedef struct packed {
        logic rst_hold;
        logic clk_run;
    } ctl_t;

    typedef struct packed {
        logic        wr;
        logic        valid;
        reg_sel_e    sel;
        logic [31:0] data;
    } bus_req_t;

    localparam ctl_t CTL_POR = '{rst_hold: 1'b1, clk_run: 1'b0};

    function automatic logic sel_in_map(input logic [2:0] word);
        return word <= 3'd5;
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst)      st <= '0;
                else if (adv) st <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst)      st <= '0;
                else if (adv) st <= {st[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = st[STAGES-1];

    // R10: no movement while the clock is stopped
    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(q));

endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    output ctl_t             ctl_o,
    output logic [NPINS-1:0] dir_o,
    output logic [NPINS-1:0] out_o,
    output logic [NPINS-1:0] ie_o
);
    logic [NPINS-1:0] wmask, wval;
    logic             accept;

    assign wmask  = req.data[16 +: NPINS];
    assign wval   = req.data[0 +: NPINS];
    assign accept = ctl_o.clk_run && !ctl_o.rst_hold && req.wr && req.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_o <= CTL_POR;
            dir_o <= '0;
            out_o <= '0;
            ie_o  <= '0;
        end else begin
            if (ctl_o.rst_hold) begin
                dir_o <= '0;
                out_o <= '0;
                ie_o  <= '0;
            end else if (accept) begin
                case (req.sel)
                    RG_DIR:  dir_o <= wval;
                    RG_OUT:  out_o <= (out_o & ~wmask) | (wval & wmask);
                    RG_IEN:  ie_o  <= wval;
                    default: ;
                endcase
            end
            if (req.wr && req.valid && req.sel == RG_CTL)
                ctl_o <= ctl_t'(req.data[1:0]);
        end
    end

    // R3: held clear while in soft reset
    a_r3_clear_in_reset: assert property (@(posedge clk) disable iff (rst)
        ctl_o.rst_hold |=> (dir_o == '0 && out_o == '0 && ie_o == '0));

    // R2: nothing but control moves while clock is stopped
    a_r2_gated_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctl_o.clk_run && !ctl_o.rst_hold) |=>
            ($stable(dir_o) && $stable(out_o) && $stable(ie_o)));

    // R5: unmasked pins keep their level
    a_r5_unmasked_keep: assert property (@(posedge clk) disable iff (rst)
        (accept && req.sel == RG_OUT) |=>
            (((out_o ^ $past(out_o)) & ~$past(wmask)) == '0));

endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq #(
    parameter int NPINS     = 16,
    parameter int SHARED_LO = 8
) (
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] ie,
    output logic             irq
);
    localparam int NSH = NPINS - SHARED_LO;
    logic [NSH-1:0] term;

    generate
        for (genvar i = 0; i < NSH; i++) begin : g_term
            assign term[i] = lvl[SHARED_LO+i] & ie[SHARED_LO+i];
        end
    endgenerate

    assign irq = |term;

endmodule

// File: rtl/pinbank_ctl.sv
module pinbank_ctl
    import pinbank_pkg::*;
#(
    parameter int NPINS       = 16,
    parameter int SHARED_LO   = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_out,
    output logic              irq_shared
);
    localparam int WORD_W = ADDR_W - 2;

    bus_req_t         req;
    ctl_t             ctl;
    logic [NPINS-1:0] dir_q, out_q, ie_q, lvl;
    logic [WORD_W-1:0] word;

    assign word = bus_addr[ADDR_W-1:2];

    always_comb begin
        req.wr    = bus_wr;
        req.valid = (word <= WORD_W'(5)) && sel_in_map(word[2:0]);
        req.sel   = reg_sel_e'(word[2:0]);
        req.data  = bus_wdata;
    end

    pinbank_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst(rst), .req(req),
        .ctl_o(ctl), .dir_o(dir_q), .out_o(out_q), .ie_o(ie_q)
    );

    pinbank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .adv(ctl.clk_run), .d(pin_in), .q(lvl)
    );

    pinbank_irq #(.NPINS(NPINS), .SHARED_LO(SHARED_LO)) u_irq (
        .lvl(lvl), .ie(ie_q), .irq(irq_shared)
    );

    always_comb begin
        bus_rdata = '0;
        if (ctl.clk_run && req.valid) begin
            case (req.sel)
                RG_DIR:  bus_rdata[NPINS-1:0] = dir_q;
                RG_OUT:  bus_rdata[NPINS-1:0] = out_q;
                RG_LVL:  bus_rdata[NPINS-1:0] = lvl;
                RG_IEN:  bus_rdata[NPINS-1:0] = ie_q;
                RG_CTL:  bus_rdata[1:0]       = ctl;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign pin_oe  = dir_q;
    assign pin_out = out_q;

    // R7: a request needs at least one upper enable bit
    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq_shared |-> (ie_q[NPINS-1:SHARED_LO] != '0));

    // R2: reads are silent with the clock stopped
    a_r2_quiet_read: assert property (@(posedge clk) disable iff (rst)
        !ctl.clk_run |-> (bus_rdata == '0));

endmodule

// File: tb/sim_pinbank_ctl.sv
`timescale 1ns/100ps
module sim_pinbank_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_oe, pin_out;
    logic        irq_shared;

    int    tests = 0;
    int    fails = 0;
    bit    done  = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    logic [1:0]  m_en;
    logic [15:0] m_dir, m_out, m_ie, m_s1, m_s2;
    logic [1:0]  en_old;

    always #2.5 clk = ~clk;

    pinbank_ctl u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .irq_shared(irq_shared)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_en = 2'b10; m_dir = '0; m_out = '0; m_ie = '0; m_s1 = '0; m_s2 = '0;
        end else begin
            en_old = m_en;
            if (en_old[0]) begin m_s2 = m_s1; m_s1 = pin_in; end
            if (en_old[1]) begin
                m_dir = '0; m_out = '0; m_ie = '0;
            end else if (en_old[0] && bus_wr) begin
                case (int'(bus_addr) / 4)
                    0: m_dir = bus_wdata[15:0];
                    2: m_out = (m_out & ~bus_wdata[31:16]) | (bus_wdata[15:0] & bus_wdata[31:16]);
                    4: m_ie  = bus_wdata[15:0];
                    default: ;
                endcase
            end
            if (bus_wr && int'(bus_addr) / 4 == 5) m_en = bus_wdata[1:0];
        end
    end

    function automatic logic [31:0] exp_rd();
        if (!m_en[0]) return 32'h0;
        case (int'(bus_addr) / 4)
            0: return {16'h0, m_dir};
            2: return {16'h0, m_out};
            3: return {16'h0, m_s2};
            4: return {16'h0, m_ie};
            5: return {30'h0, m_en};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
        end
    endtask

    task automatic compare_all();
        chk("pin_oe",  {16'h0, pin_oe},  {16'h0, m_dir});
        chk("pin_out", {16'h0, pin_out}, {16'h0, m_out});
        chk("irq",     {31'h0, irq_shared}, {31'h0, |(m_s2[15:8] & m_ie[15:8])});
        chk("rdata",   bus_rdata, exp_rd());
    endtask

    task automatic cyc(input logic wr, input logic [4:0] a, input logic [31:0] d);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic rd(input logic [4:0] a);
        cyc(1'b0, a, 32'h0);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        cyc(1'b1, a, d);
    endtask

    task automatic rd_all();
        for (int k = 0; k < 8; k++) rd(5'(k * 4));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL %s watchdog: got hang expected completion", cur_req);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        rst = 1'b1;
        repeat (3) rd(5'h00);
        rst = 1'b0;
        rd_all();

        // R2 gated writes and silent reads
        cur_req = "R2";
        wr(5'h00, 32'h0000_FFFF);
        wr(5'h14, 32'h0);
        wr(5'h00, 32'h0000_FFFF);
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h10, 32'h0000_FFFF);
        rd_all();

        // R8 control encoding
        cur_req = "R8";
        wr(5'h14, 32'h3);
        rd(5'h14);
        wr(5'h14, 32'h1);
        rd(5'h14);

        // R4 direction
        cur_req = "R4";
        wr(5'h00, 32'h0000_00F0);
        rd(5'h00);
        wr(5'h00, 32'h0000_8001);
        rd(5'h00);

        // R5 masked output writes
        cur_req = "R5";
        wr(5'h08, 32'h0001_0001 << 3);
        rd(5'h08);
        wr(5'h08, 32'h0001_0001 << 15);
        wr(5'h08, 32'h0001_0000 << 3);
        rd(5'h08);
        wr(5'h08, 32'hFFFF_A5A5);
        rd(5'h08);
        wr(5'h08, 32'h0000_5A5A);
        rd(5'h08);
        wr(5'h08, 32'h00F0_0F0F);
        rd(5'h08);

        // R6 pin-state latency
        cur_req = "R6";
        pin_in = 16'h1234;
        repeat (4) rd(5'h0C);
        pin_in = 16'hCAFE;
        wr(5'h0C, 32'hFFFF_FFFF);
        repeat (3) rd(5'h0C);

        // R7 shared interrupt
        cur_req = "R7";
        pin_in = 16'h00FF;
        wr(5'h10, 32'h0000_00FF);
        repeat (3) rd(5'h10);
        pin_in = 16'h0100;
        wr(5'h10, 32'h0000_0100);
        repeat (3) rd(5'h10);
        pin_in = 16'h8000;
        repeat (3) rd(5'h0C);
        wr(5'h10, 32'h0000_8000);
        rd(5'h10);
        pin_in = 16'h0000;
        repeat (3) rd(5'h0C);

        // R9 reserved and unmapped addresses
        cur_req = "R9";
        wr(5'h04, 32'hFFFF_FFFF);
        wr(5'h18, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd_all();

        // R10 frozen synchronizer
        cur_req = "R10";
        wr(5'h10, 32'h0000_FF00);
        pin_in = 16'h1234;
        repeat (3) rd(5'h0C);
        wr(5'h14, 32'h0);
        pin_in = 16'h0000;
        repeat (4) rd(5'h0C);
        wr(5'h14, 32'h1);
        repeat (3) rd(5'h0C);

        // R3 soft reset holds registers clear
        cur_req = "R3";
        wr(5'h00, 32'h0000_FFFF);
        wr(5'h14, 32'h3);
        rd(5'h00);
        wr(5'h00, 32'h0000_FFFF);
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h10, 32'h0000_FFFF);
        rd_all();
        wr(5'h14, 32'h1);
        rd_all();

        // R2 low-power state
        cur_req = "R2";
        wr(5'h14, 32'h2);
        rd_all();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule